// File: doc/BRIEF.md
# Single-Cycle Parallel Stochastic Number Generator

This block turns an `IN_W`-bit unsigned binary value into a stochastic word of `NB = 2^IN_W` bits, all produced together, in which the number of ones equals the binary value. The value is first spread into a thermometer-like word by wiring alone. Input bit i fills a group of 2^i adjacent positions, and the top position is held at zero so the word is exactly `NB` bits wide. That word then passes through a cascade of 2·`IN_W` permutation stages. The first `IN_W` stages perform a perfect shuffle and then a row of pair switches. The last `IN_W` stages perform a row of pair switches and then an inverse shuffle. The result is captured in an output register.

All pair switches take their select bits from one `NB/2`-bit maximal-length Fibonacci LFSR, which steps on every clock. Each stage sees that LFSR word rotated left by a fixed, wired amount. Stage s (counting from zero) uses floor(s·NB / (4·IN_W)), plus the instance offset `SHARE_OFS`, taken modulo `NB/2`. Instances built with the same seed but with different `SHARE_OFS` values behave as generators that share one LFSR and draw differently rotated control words from it. A new word is available one clock after the input is presented with enable high.

The design holds no state machine. Its only sequential elements are the LFSR register and the output register, and both are cleared or seeded by the asynchronous active-low reset.

Top module: `par_sng`

## Requirements
- R1: The expanded word maps input bit i onto positions 2^i−1 through 2^(i+1)−2, and its top position NB−1 is always 0, so the word holds exactly as many ones as the input value.
- R2: Every word loaded into the output holds a number of ones equal to the binary input sampled at the loading edge.
- R3: For the largest input value 2^IN_W−1, the output has exactly one zero bit.
- R4: The output is loaded at each rising clock edge where `en_i` is 1, so a value presented before such an edge is visible right after it, one cycle of latency.
- R5: While `en_i` is 0, the output keeps its value whatever `bin_i` does.
- R6: Reset (`rst_ni` = 0) clears the output to all zeros and loads the LFSR with the nonzero seed. The output stays zero after reset until an enabled edge.
- R7: The LFSR steps on every clock, never enters the all-zero state, and so with a fixed input the placement of the ones changes from cycle to cycle.
- R8: Stage s rotates the LFSR word left by (floor(s·NB/(4·IN_W)) + SHARE_OFS) mod NB/2 positions before using it as switch selects.
- R9: Two instances that differ only in `SHARE_OFS` produce different output sequences. An offset of exactly NB/2 gives the same sequence as an offset of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Load enable for the output register |
| bin_i | input | IN_W | Unsigned binary value to convert |
| sn_o | output | NB | Registered stochastic word |

## Verification
The hardest behaviour to see from the ports is the rotation applied to each stage's control word. The permutation scrambles the bits, and the count of ones alone cannot show it. The stimulus therefore runs three instances side by side on one input sequence, with offsets 0, 3 and NB/2. It checks that the offset-3 instance diverges from the zero-offset one, and that the NB/2 instance matches it word for word on every cycle. A single-one input held over many cycles shows that the one wanders across many positions, which shows that the LFSR is stepping and the stages are actually switching.

// File: rtl/psng_pkg.sv
package psng_pkg;

    typedef enum logic {
        STAGE_OMEGA = 1'b0,
        STAGE_FLIP  = 1'b1
    } stage_kind_e;

    // Perfect-shuffle destination of index idx: rotate its bits left by one.
    function automatic int shuffle_idx(input int idx, input int bits);
        return ((idx << 1) | (idx >> (bits - 1))) & ((1 << bits) - 1);
    endfunction

    // Left-rotation of the LFSR word seen by stage s (zero based).
    function automatic int ctrl_rot(input int s, input int nb, input int lg, input int ofs);
        return ((s * nb) / (4 * lg) + ofs) % (nb / 2);
    endfunction

endpackage

// File: rtl/psng_unary.sv
module psng_unary #(
    parameter int IN_W = 4,
    parameter int NB   = 1 << IN_W
) (
    input  logic [IN_W-1:0] bin_i,
    output logic [NB-1:0]   unary_o
);
    // Pure wiring: bit i fills 2^i positions starting at 2^i-1.
    for (genvar i = 0; i < IN_W; i++) begin : g_grp
        localparam int BASE = (1 << i) - 1;
        localparam int LEN  = 1 << i;
        assign unary_o[BASE +: LEN] = {LEN{bin_i[i]}};
    end
    // Pad position keeps the word exactly NB wide.
    assign unary_o[NB-1] = 1'b0;

endmodule

// File: rtl/psng_lfsr.sv
module psng_lfsr #(
    parameter int           W    = 8,
    parameter logic [W-1:0] TAPS = 8'hB8,
    parameter logic [W-1:0] SEED = 8'hA5
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    output logic [W-1:0] state_o
);
    logic [W-1:0] state_q;
    logic         fb;

    assign fb = ^(state_q & TAPS);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= SEED;
        else         state_q <= {state_q[W-2:0], fb};
    end

    assign state_o = state_q;

    // R7: the register never holds the lock-up value.
    assert_lfsr_nonzero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q != '0);

    // R7: the register changes on every clock.
    assert_lfsr_steps_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> state_q != $past(state_q));

endmodule

// File: rtl/psng_perm_stage.sv
module psng_perm_stage #(
    parameter int                    LG   = 4,
    parameter int                    NB   = 1 << LG,
    parameter psng_pkg::stage_kind_e KIND = psng_pkg::STAGE_OMEGA
) (
    input  logic [NB-1:0]   din_i,
    input  logic [NB/2-1:0] sel_i,
    output logic [NB-1:0]   dout_o
);
    logic [NB-1:0] mid;

    if (KIND == psng_pkg::STAGE_OMEGA) begin : g_omega
        // Shuffle first, then the row of pair switches.
        for (genvar j = 0; j < NB; j++) begin : g_shuf
            localparam int DST = psng_pkg::shuffle_idx(j, LG);
            assign mid[DST] = din_i[j];
        end
        for (genvar k = 0; k < NB/2; k++) begin : g_sw
            assign dout_o[2*k]   = sel_i[k] ? mid[2*k+1] : mid[2*k];
            assign dout_o[2*k+1] = sel_i[k] ? mid[2*k]   : mid[2*k+1];
        end
    end else begin : g_flip
        // Pair switches first, then the inverse shuffle.
        for (genvar k = 0; k < NB/2; k++) begin : g_sw
            assign mid[2*k]   = sel_i[k] ? din_i[2*k+1] : din_i[2*k];
            assign mid[2*k+1] = sel_i[k] ? din_i[2*k]   : din_i[2*k+1];
        end
        for (genvar j = 0; j < NB; j++) begin : g_ishuf
            localparam int SRC = psng_pkg::shuffle_idx(j, LG);
            assign dout_o[j] = mid[SRC];
        end
    end

endmodule

// File: rtl/par_sng.sv
module par_sng #(
    parameter int                          IN_W      = 4,
    parameter logic [(1<<IN_W)/2-1:0]      TAPS      = 'hB8,
    parameter logic [(1<<IN_W)/2-1:0]      SEED      = 'hA5,
    parameter int                          SHARE_OFS = 0
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  en_i,
    input  logic [IN_W-1:0]       bin_i,
    output logic [(1<<IN_W)-1:0]  sn_o
);
    localparam int NB     = 1 << IN_W;
    localparam int CW     = NB / 2;
    localparam int STAGES = 2 * IN_W;

    logic [NB-1:0] unary;
    logic [CW-1:0] lfsr_q;
    logic [CW-1:0] sel   [STAGES];
    logic [NB-1:0] lane  [STAGES+1];
    logic [NB-1:0] sn_q;

    psng_unary #(.IN_W(IN_W), .NB(NB)) u_unary (
        .bin_i   (bin_i),
        .unary_o (unary)
    );

    psng_lfsr #(.W(CW), .TAPS(TAPS), .SEED(SEED)) u_lfsr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .state_o (lfsr_q)
    );

    assign lane[0] = unary;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        localparam int ROT = psng_pkg::ctrl_rot(s, NB, IN_W, SHARE_OFS);
        localparam psng_pkg::stage_kind_e KIND =
            (s < IN_W) ? psng_pkg::STAGE_OMEGA : psng_pkg::STAGE_FLIP;

        // R8: fixed left rotation of the shared LFSR word.
        for (genvar b = 0; b < CW; b++) begin : g_rot
            assign sel[s][b] = lfsr_q[(b - ROT + CW) % CW];
        end

        psng_perm_stage #(.LG(IN_W), .NB(NB), .KIND(KIND)) u_stage (
            .din_i  (lane[s]),
            .sel_i  (sel[s]),
            .dout_o (lane[s+1])
        );
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   sn_q <= '0;
        else if (en_i) sn_q <= lane[STAGES];
    end

    assign sn_o = sn_q;

    // R1: the expanded word carries as many ones as the input value.
    assert_unary_count_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(unary) == int'(bin_i));

    // R2: a loaded word carries as many ones as the input sampled at the load.
    assert_out_ones_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_i |=> $countones(sn_q) == int'($past(bin_i)));

    // R5: no load without enable.
    assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(sn_q));

endmodule

// File: tb/par_sng_tb_top.sv
`timescale 1ns/1ps
module par_sng_tb_top;
    localparam int IN_W = 4;
    localparam int NB   = 1 << IN_W;
    localparam int CW   = NB / 2;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic          en = 1'b0;
    logic [IN_W-1:0] bin = '0;
    logic [NB-1:0] sn_a, sn_b, sn_c;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    par_sng #(.IN_W(IN_W), .SHARE_OFS(0)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .bin_i(bin), .sn_o(sn_a));
    par_sng #(.IN_W(IN_W), .SHARE_OFS(3)) dut_ofs3 (
        .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .bin_i(bin), .sn_o(sn_b));
    par_sng #(.IN_W(IN_W), .SHARE_OFS(CW)) dut_ofsw (
        .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .bin_i(bin), .sn_o(sn_c));

    function automatic int ones(input logic [NB-1:0] w);
        int c = 0;
        for (int i = 0; i < NB; i++) c += int'(w[i]);
        return c;
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R6: reset state, and no load while enable stays low.
    task automatic t_reset();
        check(sn_a == '0, "R6 output zero in reset", sn_a, 0);
        @(negedge clk); rst_ni = 1'b1; bin = 4'd9;
        repeat (3) @(negedge clk);
        check(sn_a == '0, "R6 output zero after reset without enable", sn_a, 0);
    endtask

    // R1 R2 R4: new value every cycle, seen one edge later.
    task automatic t_sweep();
        en = 1'b1;
        for (int v = 0; v < NB; v++) begin
            bin = v[IN_W-1:0];
            @(negedge clk);
            check(ones(sn_a) == v, "R2 R1 R4 ones count after one edge", ones(sn_a), v);
        end
        for (int v = NB - 1; v >= 0; v -= 5) begin
            bin = v[IN_W-1:0];
            @(negedge clk);
            check(ones(sn_a) == v, "R2 descending ones count", ones(sn_a), v);
        end
    endtask

    // R3: largest value leaves exactly one zero; zero gives all zeros.
    task automatic t_extremes();
        en = 1'b1;
        bin = '1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            check(ones(~sn_a) == 1, "R3 one zero at max input", ones(~sn_a), 1);
        end
        bin = '0;
        @(negedge clk);
        check(sn_a == '0, "R2 zero input gives zero word", sn_a, 0);
    endtask

    // R5: output frozen while enable low, bin changing.
    task automatic t_hold();
        logic [NB-1:0] snap;
        en = 1'b1; bin = 4'd6;
        @(negedge clk);
        snap = sn_a;
        en = 1'b0;
        for (int c = 0; c < 5; c++) begin
            bin = 4'(c * 3 + 1);
            @(negedge clk);
            check(sn_a == snap, "R5 hold while disabled", sn_a, snap);
        end
        en = 1'b1;
        @(negedge clk);
        check(ones(sn_a) == int'(bin), "R4 load resumes after enable", ones(sn_a), bin);
    endtask

    // R7: a single one wanders over many positions.
    task automatic t_wander();
        logic [NB-1:0] seen = '0;
        logic [NB-1:0] first;
        bit changed = 1'b0;
        en = 1'b1; bin = 4'd1;
        @(negedge clk);
        first = sn_a;
        for (int c = 0; c < 48; c++) begin
            @(negedge clk);
            seen |= sn_a;
            if (sn_a != first) changed = 1'b1;
        end
        check(changed, "R7 placement changes over time", changed, 1);
        check(ones(seen) >= 4, "R7 single one reaches many positions", ones(seen), 4);
    endtask

    // R8 R9: offsets change the sequence; offset NB/2 wraps to offset 0.
    task automatic t_share();
        bit differs = 1'b0;
        en = 1'b1; bin = 4'd8;
        for (int c = 0; c < 32; c++) begin
            @(negedge clk);
            if (sn_b != sn_a) differs = 1'b1;
            check(sn_c == sn_a, "R9 R8 wrapped offset matches zero offset", sn_c, sn_a);
        end
        check(differs, "R9 distinct offsets diverge", differs, 1);
        check(ones(sn_b) == 8, "R2 offset instance keeps ones count", ones(sn_b), 8);
    endtask

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #5;
        t_reset();
        t_sweep();
        t_extremes();
        t_hold();
        t_wander();
        t_share();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule